// File: doc/BRIEF.md
# Byte-Wide Flash Command Controller

This block is the command front end of a byte-wide flash die. It decodes two fixed unlock writes and a command byte from ordinary bus write cycles, then runs one of three embedded operations: program one byte, erase a chosen set of sectors, or erase the whole array. The array is a small behavioural register store. It has 32 sectors of `SECT_BYTES` bytes each. Bits [15:11] of the address select the sector and bits [1:0] select the byte; the address bits between them are ignored for array access. Program, erase and erase-queue durations are parameters given in clock cycles.

While an operation runs, reads of the affected location return a status byte instead of data, and `ready_o` is low. A host uses either the status byte or `ready_o` to learn when the operation is done. The active-low asynchronous reset stops any operation and puts the decoder back in read mode. Array contents survive the reset.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset `ready_o` is 1. A reset taken during a program stops it, leaves the target byte unchanged, and releases `ready_o` at once. `rdata_o` changes only in the cycle after a read strobe.
- R2: A program is four writes: AAh to 5555h, 55h to 2AAAh, A0h to 5555h, then the data to the target. The command addresses are compared on address bits [14:0]. When the operation ends, the target holds old AND data.
- R3: `ready_o` is low for exactly `PROG_CYC` cycles after the final program write. During that time a read of the target returns bit 7 = inverted data bit 7, bit 6 = a toggle bit that flips on every status read, and bits [5:0] = 0. Other addresses return array data.
- R4: Any write that does not match the expected next step returns the decoder to read mode. No operation starts and the array does not change.
- R5: Six writes (AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, 10h@5555h) erase the whole array to FFh. `ready_o` is low for exactly `ERASE_CYC` cycles.
- R6: The same six writes ending in 30h to any address in a sector erase only that sector to FFh. The erase starts after a queue window of `ERASE_WIN` cycles.
- R7: During the queue window, a write of 30h to an address adds that address's sector to the erase and restarts the window. Other writes in the window are ignored.
- R8: During an erase, reads of sectors not being erased return array data. Reads of an erasing sector return bit 7 = 0, the toggle bit on bit 6, and bits [5:0] = 0.
- R9: After the queue window, a program to a sector that is not being erased runs and completes. A program aimed at an erasing sector is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset, back to read mode |
| we_i | input | 1 | One-cycle bus write strobe |
| re_i | input | 1 | One-cycle bus read strobe |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 8 | Write data or command byte |
| rdata_o | output | 8 | Read data or status byte, valid the cycle after `re_i` |
| ready_o | output | 1 | 1 = released (ready), 0 = driven low (busy) |

## Verification
The hardest state to reach is a program running at the same time as a sector erase. The unlock writes are ignored during the queue window, so the stimulus first waits past `ERASE_WIN`. It then issues one program to an untouched sector and one to the erasing sector, and reads both locations while the erase still runs and again after it ends. The reset-abort case is reached by pulsing reset a few cycles into a program and then reading the target back.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  localparam int CMD_AW = 15;
  localparam logic [CMD_AW-1:0] ADR_KEY1 = 15'h5555;
  localparam logic [CMD_AW-1:0] ADR_KEY2 = 15'h2AAA;
  localparam logic [7:0] CMD_KEY1  = 8'hAA;
  localparam logic [7:0] CMD_KEY2  = 8'h55;
  localparam logic [7:0] CMD_PROG  = 8'hA0;
  localparam logic [7:0] CMD_ERASE = 8'h80;
  localparam logic [7:0] CMD_CHIP  = 8'h10;
  localparam logic [7:0] CMD_SECT  = 8'h30;

  typedef enum logic [2:0] {
    S_READ, S_K1, S_K2, S_PGDATA, S_E3, S_E4, S_E5
  } dec_state_e;

  typedef enum logic [1:0] {ER_IDLE, ER_WIN, ER_RUN} er_state_e;
endpackage

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [CMD_AW-1:0] addr_i,
  input  logic [7:0]        data_i,
  input  logic              erase_lock_i,
  output logic              prog_o,
  output logic              chip_o,
  output logic              sect_o,
  output dec_state_e        state_o
);
  dec_state_e state_q, state_d;

  logic at_k1, at_k2;
  assign at_k1 = (addr_i == ADR_KEY1);
  assign at_k2 = (addr_i == ADR_KEY2);

  always_comb begin
    state_d = state_q;
    prog_o  = 1'b0;
    chip_o  = 1'b0;
    sect_o  = 1'b0;
    if (wr_i) begin
      state_d = S_READ;  // any mismatch falls back to read mode
      unique case (state_q)
        S_READ:   if (at_k1 && data_i == CMD_KEY1) state_d = S_K1;
        S_K1:     if (at_k2 && data_i == CMD_KEY2) state_d = S_K2;
        S_K2: begin
          if (at_k1 && data_i == CMD_PROG) state_d = S_PGDATA;
          else if (at_k1 && data_i == CMD_ERASE && !erase_lock_i) state_d = S_E3;
        end
        S_PGDATA: prog_o = 1'b1;
        S_E3:     if (at_k1 && data_i == CMD_KEY1) state_d = S_E4;
        S_E4:     if (at_k2 && data_i == CMD_KEY2) state_d = S_E5;
        S_E5: begin
          if (at_k1 && data_i == CMD_CHIP) chip_o = 1'b1;
          else if (data_i == CMD_SECT) sect_o = 1'b1;
        end
        default: state_d = S_READ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= S_READ;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/flash_prog_engine.sv
module flash_prog_engine #(
  parameter int IDX_W    = 7,
  parameter int PROG_CYC = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [7:0]       data_i,
  output logic             busy_o,
  output logic             commit_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [7:0]       data_o
);
  localparam int CNT_W = $clog2(PROG_CYC + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      idx_o  <= '0;
      data_o <= '0;
    end else if (start_i && !busy_q) begin
      busy_q <= 1'b1;
      cnt_q  <= CNT_W'(PROG_CYC - 1);
      idx_o  <= idx_i;
      data_o <= data_i;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign busy_o   = busy_q;
  assign commit_o = busy_q && (cnt_q == '0);
endmodule

// File: rtl/flash_erase_engine.sv
module flash_erase_engine
  import flash_cmd_pkg::*;
#(
  parameter int SECT_N    = 32,
  parameter int ERASE_CYC = 40,
  parameter int ERASE_WIN = 10,
  localparam int SECT_W   = $clog2(SECT_N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              chip_i,
  input  logic              sect_i,
  input  logic              add_i,
  input  logic [SECT_W-1:0] sect_idx_i,
  output logic [SECT_N-1:0] mask_o,
  output logic              win_o,
  output logic              run_o,
  output logic              commit_o
);
  localparam int MAX_C = (ERASE_CYC > ERASE_WIN) ? ERASE_CYC : ERASE_WIN;
  localparam int CNT_W = $clog2(MAX_C + 1);

  er_state_e         st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [SECT_N-1:0] mask_q;
  logic [SECT_N-1:0] sect_bit;

  assign sect_bit = SECT_N'(1) << sect_idx_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ER_IDLE;
      cnt_q  <= '0;
      mask_q <= '0;
    end else begin
      unique case (st_q)
        ER_IDLE: begin
          if (chip_i) begin
            st_q   <= ER_RUN;
            mask_q <= '1;
            cnt_q  <= CNT_W'(ERASE_CYC - 1);
          end else if (sect_i) begin
            st_q   <= ER_WIN;
            mask_q <= sect_bit;
            cnt_q  <= CNT_W'(ERASE_WIN - 1);
          end
        end
        ER_WIN: begin
          if (add_i) begin
            mask_q <= mask_q | sect_bit;
            cnt_q  <= CNT_W'(ERASE_WIN - 1);
          end else if (cnt_q == '0) begin
            st_q  <= ER_RUN;
            cnt_q <= CNT_W'(ERASE_CYC - 1);
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ER_RUN: begin
          if (cnt_q == '0) begin
            st_q   <= ER_IDLE;
            mask_q <= '0;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: st_q <= ER_IDLE;
      endcase
    end
  end

  assign mask_o   = mask_q;
  assign win_o    = (st_q == ER_WIN);
  assign run_o    = (st_q == ER_RUN);
  assign commit_o = (st_q == ER_RUN) && (cnt_q == '0);
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int SECT_N     = 32,
  parameter int SECT_BYTES = 4,
  parameter int PROG_CYC   = 12,
  parameter int ERASE_CYC  = 40,
  parameter int ERASE_WIN  = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic              ready_o
);
  localparam int SECT_W = $clog2(SECT_N);
  localparam int OFF_W  = $clog2(SECT_BYTES);
  localparam int IDX_W  = SECT_W + OFF_W;
  localparam int MEM_N  = SECT_N * SECT_BYTES;

  logic [SECT_W-1:0] wr_sect;
  logic [IDX_W-1:0]  addr_idx;
  assign wr_sect  = addr_i[ADDR_W-1 -: SECT_W];
  assign addr_idx = {wr_sect, addr_i[OFF_W-1:0]};

  // engines
  logic              prog_busy, prog_commit, prog_start;
  logic [IDX_W-1:0]  prog_idx;
  logic [7:0]        prog_data;
  logic              erase_win, erase_run, erase_commit, erase_act;
  logic [SECT_N-1:0] erase_mask;
  logic              dec_prog, dec_chip, dec_sect, dec_wr, win_add;
  dec_state_e        dec_state;

  assign erase_act = erase_win | erase_run;
  assign dec_wr    = we_i && !prog_busy && !erase_win;
  assign win_add   = we_i && erase_win && (wdata_i == CMD_SECT);
  assign prog_start = dec_prog && !erase_mask[wr_sect];

  flash_cmd_decoder u_dec (
    .clk_i, .rst_ni,
    .wr_i         (dec_wr),
    .addr_i       (addr_i[CMD_AW-1:0]),
    .data_i       (wdata_i),
    .erase_lock_i (erase_act),
    .prog_o       (dec_prog),
    .chip_o       (dec_chip),
    .sect_o       (dec_sect),
    .state_o      (dec_state)
  );

  flash_prog_engine #(.IDX_W(IDX_W), .PROG_CYC(PROG_CYC)) u_prog (
    .clk_i, .rst_ni,
    .start_i  (prog_start),
    .idx_i    (addr_idx),
    .data_i   (wdata_i),
    .busy_o   (prog_busy),
    .commit_o (prog_commit),
    .idx_o    (prog_idx),
    .data_o   (prog_data)
  );

  flash_erase_engine #(.SECT_N(SECT_N), .ERASE_CYC(ERASE_CYC), .ERASE_WIN(ERASE_WIN)) u_erase (
    .clk_i, .rst_ni,
    .chip_i     (dec_chip),
    .sect_i     (dec_sect),
    .add_i      (win_add),
    .sect_idx_i (wr_sect),
    .mask_o     (erase_mask),
    .win_o      (erase_win),
    .run_o      (erase_run),
    .commit_o   (erase_commit)
  );

  // behavioural array, kept across reset
  logic [MEM_N-1:0][7:0] mem_q, mem_d;
  logic [MEM_N-1:0]      byte_clr;

  for (genvar s = 0; s < SECT_N; s++) begin : g_sect
    for (genvar b = 0; b < SECT_BYTES; b++) begin : g_byte
      assign byte_clr[s*SECT_BYTES+b] = erase_commit & erase_mask[s];
    end
  end

  for (genvar i = 0; i < MEM_N; i++) begin : g_mem
    assign mem_d[i] = byte_clr[i] ? 8'hFF :
                      (prog_commit && prog_idx == IDX_W'(i)) ? (mem_q[i] & prog_data) :
                      mem_q[i];
  end

  always_ff @(posedge clk_i) mem_q <= mem_d;

  // read path with status override
  logic tog_q;
  logic hit_prog, hit_erase;
  assign hit_prog  = prog_busy && (addr_idx == prog_idx);
  assign hit_erase = erase_act && erase_mask[wr_sect];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
      tog_q   <= 1'b0;
    end else if (re_i) begin
      if (hit_prog) begin
        rdata_o <= {~prog_data[7], tog_q, 6'b0};
        tog_q   <= ~tog_q;
      end else if (hit_erase) begin
        rdata_o <= {1'b0, tog_q, 6'b0};
        tog_q   <= ~tog_q;
      end else begin
        rdata_o <= mem_q[addr_idx];
      end
    end
  end

  assign ready_o = !(prog_busy || erase_act);
endmodule

// File: rtl/flash_cmd_ctrl_chk.sv
module flash_cmd_ctrl_chk
  import flash_cmd_pkg::*;
#(
  parameter int SECT_N = 32,
  parameter int SECT_W = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_i,
  input logic              re_i,
  input logic [7:0]        wdata_i,
  input logic [7:0]        rdata_o,
  input logic              prog_start,
  input logic              prog_busy,
  input logic              tog_q,
  input logic              erase_act,
  input logic              erase_win,
  input logic [SECT_N-1:0] erase_mask,
  input logic [SECT_W-1:0] wr_sect,
  input dec_state_e        dec_state
);
  // R1
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> $stable(rdata_o));

  // R2
  prog_needs_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(prog_busy) |-> $past(we_i));

  // R3
  toggle_on_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> $stable(tog_q));

  // R4
  break_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !prog_busy && !erase_win && dec_state == S_READ && wdata_i != CMD_KEY1)
      |=> dec_state == S_READ);

  // R7
  mask_grow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (erase_act && $past(erase_act)) |-> ((erase_mask & $past(erase_mask)) == $past(erase_mask)));

  // R9
  prog_outside_erase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_start |-> !erase_mask[wr_sect]);
endmodule

bind flash_cmd_ctrl flash_cmd_ctrl_chk #(.SECT_N(SECT_N), .SECT_W(SECT_W)) u_chk (
  .clk_i, .rst_ni, .we_i, .re_i, .wdata_i, .rdata_o,
  .prog_start, .prog_busy, .tog_q, .erase_act, .erase_win,
  .erase_mask, .wr_sect, .dec_state
);

// File: tb/flash_cmd_ctrl_bench.sv
module flash_cmd_ctrl_bench;
  localparam int PROG_CYC  = 12;
  localparam int ERASE_CYC = 40;
  localparam int ERASE_WIN = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we_i = 1'b0, re_i = 1'b0;
  logic [15:0] addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic [7:0]  rdata_o;
  logic        ready_o;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  flash_cmd_ctrl #(.PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC), .ERASE_WIN(ERASE_WIN)) u_flash_cmd_ctrl (
    .clk_i(clk), .rst_ni, .we_i, .re_i, .addr_i, .wdata_i, .rdata_o, .ready_o
  );

  task automatic chk(input string rq, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", rq, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk); we_i = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk); re_i = 1'b1; addr_i = a;
    @(negedge clk); re_i = 1'b0; d = rdata_o;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic busy_len(output int n);
    n = 0;
    while (!ready_o && n < 2000) begin n++; @(negedge clk); end
  endtask

  task automatic prog(input logic [15:0] a, input logic [7:0] d);
    wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55); wr(16'h5555, 8'hA0); wr(a, d);
  endtask

  task automatic erase_pre();
    wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55); wr(16'h5555, 8'h80);
    wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55);
  endtask

  task automatic t_reset();
    chk("R1 ready after reset", {7'b0, ready_o}, 8'h01);
  endtask

  task automatic t_chip_erase();
    int n; logic [7:0] d;
    erase_pre(); wr(16'h5555, 8'h10);
    busy_len(n);
    chk("R5 chip erase busy cycles", 8'(n), 8'(ERASE_CYC));
    rd(16'h0000, d); chk("R5 byte 0000", d, 8'hFF);
    rd(16'h7803, d); chk("R5 byte 7803", d, 8'hFF);
    rd(16'hF802, d); chk("R5 byte F802", d, 8'hFF);
  endtask

  task automatic t_program();
    int n; logic [7:0] d;
    prog(16'h0000, 8'hA5);
    busy_len(n);
    chk("R3 program busy cycles", 8'(n), 8'(PROG_CYC));
    rd(16'h0000, d); chk("R2 program A5", d, 8'hA5);
    prog(16'h0000, 8'h0F); busy_len(n);
    rd(16'h0000, d); chk("R2 program AND", d, 8'h05);
  endtask

  task automatic t_poll();
    int n; logic [7:0] a, b, o;
    prog(16'h0801, 8'h3C);
    rd(16'h0801, a); rd(16'h0801, b); rd(16'h0000, o);
    chk("R3 poll bit7 first", {7'b0, a[7]}, 8'h01);
    chk("R3 poll bit7 second", {7'b0, b[7]}, 8'h01);
    chk("R3 toggle flips", {7'b0, a[6] ^ b[6]}, 8'h01);
    chk("R3 low bits zero", {2'b0, a[5:0]}, 8'h00);
    chk("R3 other address data", o, 8'h05);
    busy_len(n);
    rd(16'h0801, a); chk("R3 true data after", a, 8'h3C);
  endtask

  task automatic t_break();
    logic [7:0] d;
    wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55); wr(16'h5555, 8'h77); wr(16'h0002, 8'h00);
    chk("R4 ready after break", {7'b0, ready_o}, 8'h01);
    rd(16'h0002, d); chk("R4 array unchanged A", d, 8'hFF);
    wr(16'h5555, 8'hAA); wr(16'h1234, 8'h55); wr(16'h5555, 8'hA0); wr(16'h0002, 8'h00);
    idle(PROG_CYC + 2);
    rd(16'h0002, d); chk("R4 array unchanged B", d, 8'hFF);
  endtask

  task automatic t_sector_erase();
    int n; logic [7:0] d;
    prog(16'h1000, 8'h00); busy_len(n);
    prog(16'h1800, 8'h00); busy_len(n);
    erase_pre(); wr(16'h1002, 8'h30);
    busy_len(n);
    rd(16'h1000, d); chk("R6 erased sector", d, 8'hFF);
    rd(16'h1800, d); chk("R6 neighbour kept", d, 8'h00);
  endtask

  task automatic t_multi();
    int n; logic [7:0] d;
    prog(16'h2000, 8'h00); busy_len(n);
    prog(16'h3000, 8'h00); busy_len(n);
    prog(16'h3800, 8'h00); busy_len(n);
    erase_pre(); wr(16'h2000, 8'h30);
    wr(16'h3801, 8'h30);
    busy_len(n);
    rd(16'h2000, d); chk("R7 first queued", d, 8'hFF);
    rd(16'h3800, d); chk("R7 second queued", d, 8'hFF);
    rd(16'h3000, d); chk("R7 not queued", d, 8'h00);
  endtask

  task automatic t_erase_reads();
    int n; logic [7:0] a, b, o;
    prog(16'h4000, 8'h5A); busy_len(n);
    prog(16'h4800, 8'h00); busy_len(n);
    erase_pre(); wr(16'h4800, 8'h30);
    rd(16'h4000, o); rd(16'h4800, a); rd(16'h4800, b);
    chk("R8 other sector data", o, 8'h5A);
    chk("R8 status bit7 low", {a[7], 1'b0, a[5:0]}, 8'h00);
    chk("R8 toggle flips", {7'b0, a[6] ^ b[6]}, 8'h01);
    busy_len(n);
    rd(16'h4800, a); chk("R8 erased after", a, 8'hFF);
  endtask

  task automatic t_prog_during_erase();
    int n; logic [7:0] d;
    prog(16'h6000, 8'h00); busy_len(n);
    erase_pre(); wr(16'h6800, 8'h30);
    idle(ERASE_WIN + 2);
    prog(16'h7000, 8'h42);
    idle(PROG_CYC + 2);
    rd(16'h7000, d); chk("R9 program beside erase", d, 8'h42);
    chk("R9 still busy with erase", {7'b0, ready_o}, 8'h00);
    prog(16'h6801, 8'h00);
    busy_len(n);
    rd(16'h6801, d); chk("R9 program into erase dropped", d, 8'hFF);
    rd(16'h6000, d); chk("R9 other sector untouched", d, 8'h00);
  endtask

  task automatic t_reset_abort();
    logic [7:0] d;
    prog(16'h7800, 8'h00);
    idle(3);
    rst_ni = 1'b0;
    @(negedge clk);
    chk("R1 ready during reset", {7'b0, ready_o}, 8'h01);
    rst_ni = 1'b1;
    idle(PROG_CYC + 2);
    rd(16'h7800, d); chk("R1 aborted target kept", d, 8'hFF);
  endtask

  initial begin
    idle(3);
    rst_ni = 1'b1;
    idle(1);
    t_reset();
    t_chip_erase();
    t_program();
    t_poll();
    t_break();
    t_sector_erase();
    t_multi();
    t_erase_reads();
    t_prog_during_erase();
    t_reset_abort();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule